// File: doc/BRIEF.md
# Receive Mailbox Engine

This block is the host-side handler for messages that a coprocessor posts into a shared byte-wide RAM. There are seven channels. Each channel has a 32-byte message slot and a one-byte slot state. When the incoming-message interrupt arrives, the engine reads every channel's state byte in ascending order. For each channel that holds a fresh message, it streams the 32 bytes out to consumer logic, tagged with the channel number and byte index. It then marks the slot as taken.

A per-channel registration mask records which channels have a consumer attached. On a registered channel the slot waits in the taken state until the consumer hands back a 32-byte reply. The engine writes that reply into the same slot, marks the slot finished and rings the doorbell to the coprocessor. A channel with no consumer is finished at once and its buffer is left as it was, so the coprocessor never waits on a message nobody will answer. The coprocessor, not this block, returns a finished slot to idle.

Replies can arrive while a scan is running. They are parked, one per channel, and written back once the engine is free, lowest channel first.

Top module: `mbox_rx_engine`

## Requirements
- R1: After reset, `doorbell`, `out_valid`, `out_last`, `mem_en`, `rep_err` and `cons_reject` are all low.
- R2: A pulse on `irq_msg` starts a scan of channels 0 to 6 in ascending order. Slot states use the codes 0 idle, 1 new, 2 taken and 3 finished. Byte i of channel c sits at address MSG_BASE + 32*c + i (default MSG_BASE 0), and the state of channel c sits at STATE_BASE + c (default 224). Each channel whose state reads 1 has its 32 bytes streamed on `out_byte`, with `out_chan` = c and `out_idx` counting 0 to 31. `out_last` is high on index 31.
- R3: The write that follows the last streamed byte of a channel sets that channel's state to 2, and the copy writes nothing into the message slot.
- R4: On a channel registered in the consumer mask, the state stays at 2 and no doorbell is raised for it until a reply is accepted.
- R5: An accepted reply writes `rep_data[8*i+7:8*i]` into byte i of the channel's slot. It then writes state 3 and raises `doorbell` for exactly one cycle.
- R6: On a channel that is not registered, state 3 is written in the cycle after state 2, together with a doorbell pulse, and the slot bytes are left unchanged.
- R7: The engine never writes code 0 to a state byte. A channel whose state is not 1 during a scan is neither streamed nor written.
- R8: `cons_set` on a channel that is already registered, or on a channel number of 7 or more, pulses `cons_reject` in the next cycle and leaves the mask unchanged. `cons_clr` always removes the registration and is never rejected; if `cons_set` and `cons_clr` come together, the clear applies.
- R9: A reply is refused with a one-cycle `rep_err` pulse, and causes no RAM write, if its channel is out of range, is not waiting in state 2, or already holds a parked reply.
- R10: When several replies are parked, they are written back in ascending channel order, each one complete (32 bytes, state, doorbell) before the next begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_msg | input | 1 | Incoming-message interrupt from the coprocessor |
| cons_set | input | 1 | Register a consumer on `cons_chan` |
| cons_clr | input | 1 | Remove the consumer on `cons_chan` |
| cons_chan | input | 3 | Channel for a registration request |
| cons_reject | output | 1 | Registration request refused |
| rep_valid | input | 1 | Reply offered by the consumer |
| rep_chan | input | 3 | Channel of the offered reply |
| rep_data | input | 256 | Reply bytes, byte i in bits 8i+7:8i |
| rep_err | output | 1 | Reply refused |
| out_valid | output | 1 | Streamed message byte valid |
| out_chan | output | 3 | Channel of the streamed byte |
| out_idx | output | 5 | Byte index within the message |
| out_byte | output | 8 | Streamed message byte |
| out_last | output | 1 | Final byte of a message |
| mem_en | output | 1 | Shared RAM access strobe |
| mem_we | output | 1 | Shared RAM write (else read) |
| mem_addr | output | 8 | Shared RAM byte address |
| mem_wdata | output | 8 | Shared RAM write data |
| mem_rdata | input | 8 | Shared RAM read data, valid the cycle after a read strobe |
| doorbell | output | 1 | Completion signal to the coprocessor |

## Verification
The assertions assume two things about the shared RAM. First, it returns read data exactly one cycle after the read strobe. Second, the coprocessor changes no state byte while the engine is touching that channel. Under these assumptions, the streamed indices run without gaps and the taken-state write lines up with the last byte. The bench models the RAM with that fixed latency. It writes state bytes only between runs, while the engine is idle, and it offers replies only for channels it expects to be waiting or deliberately wrong ones.

// File: rtl/mbox_rx_pkg.sv
package mbox_rx_pkg;

  // Slot state codes shared with the coprocessor
  localparam logic [7:0] SLOT_IDLE  = 8'h00;
  localparam logic [7:0] SLOT_NEW   = 8'h01;
  localparam logic [7:0] SLOT_TAKEN = 8'h02;
  localparam logic [7:0] SLOT_DONE  = 8'h03;

  typedef enum logic [2:0] {
    E_IDLE,
    E_ST_RD,
    E_ST_CHK,
    E_COPY,
    E_TAIL,
    E_AUTO,
    E_WB,
    E_WB_FIN
  } seq_state_e;

endpackage

// File: rtl/mbox_rx_consumers.sv
module mbox_rx_consumers #(
  parameter int N_CH = 7,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_req,
  input  logic            clr_req,
  input  logic [CH_W-1:0] chan,
  output logic [N_CH-1:0] mask,
  output logic            reject
);

  logic [N_CH-1:0] mask_q, mask_d;
  logic            rej_q, rej_d;
  logic            in_rng;

  assign in_rng = int'(chan) < N_CH;

  always_comb begin
    mask_d = mask_q;
    rej_d  = 1'b0;
    if (clr_req) begin
      for (int i = 0; i < N_CH; i++)
        if (chan == CH_W'(i)) mask_d[i] = 1'b0;
    end else if (set_req) begin
      if (!in_rng) begin
        rej_d = 1'b1;
      end else begin
        for (int i = 0; i < N_CH; i++) begin
          if (chan == CH_W'(i)) begin
            if (mask_q[i]) rej_d = 1'b1;
            else           mask_d[i] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rej_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      rej_q  <= rej_d;
    end
  end

  assign mask   = mask_q;
  assign reject = rej_q;

  // R8: a refused request leaves the registration mask as it was
  a_r8_reject_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (mask == $past(mask)));

endmodule

// File: rtl/mbox_rx_replies.sv
module mbox_rx_replies #(
  parameter int N_CH      = 7,
  parameter int CH_W      = 3,
  parameter int MSG_BYTES = 32,
  parameter int IDX_W     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rep_valid,
  input  logic [CH_W-1:0]        rep_chan,
  input  logic [MSG_BYTES*8-1:0] rep_data,
  input  logic                   arm,
  input  logic                   wb_done,
  input  logic [CH_W-1:0]        cur_chan,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [7:0]             rd_byte,
  output logic [N_CH-1:0]        pend,
  output logic                   rep_err
);

  localparam int WORD_W = MSG_BYTES * 8;

  logic [WORD_W-1:0] buf_q [N_CH];
  logic [N_CH-1:0]   wait_q, wait_d, pend_q, pend_d;
  logic              err_q, err_d;
  logic              hit, accept;
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < N_CH; i++)
      if (rep_chan == CH_W'(i)) hit = wait_q[i] & ~pend_q[i];
  end

  assign accept = rep_valid & hit & (int'(rep_chan) < N_CH);

  always_comb begin
    wait_d = wait_q;
    pend_d = pend_q;
    err_d  = rep_valid & ~accept;
    for (int i = 0; i < N_CH; i++) begin
      if (arm && cur_chan == CH_W'(i))     wait_d[i] = 1'b1;
      if (accept && rep_chan == CH_W'(i))  pend_d[i] = 1'b1;
      if (wb_done && cur_chan == CH_W'(i)) begin
        wait_d[i] = 1'b0;
        pend_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      wait_q <= wait_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  // Reply storage: data only, enabled by acceptance
  always_ff @(posedge clk) begin
    if (accept) buf_q[rep_chan] <= rep_data;
  end

  assign sel_word = buf_q[cur_chan];
  assign rd_byte  = sel_word[{rd_idx, 3'b000} +: 8];
  assign pend     = pend_q;
  assign rep_err  = err_q;

  // R9: a refused reply parks nothing
  a_r9_err_adds_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    rep_err |-> ($countones(pend_q) <= $countones($past(pend_q))));

  // R4: a parked reply only exists for a channel waiting in the taken state
  a_r4_pend_needs_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~wait_q) == '0);

endmodule

// File: rtl/mbox_rx_seq.sv
module mbox_rx_seq
  import mbox_rx_pkg::*;
#(
  parameter int N_CH       = 7,
  parameter int CH_W       = 3,
  parameter int MSG_BYTES  = 32,
  parameter int IDX_W      = 5,
  parameter int ADDR_W     = 8,
  parameter int MSG_BASE   = 0,
  parameter int STATE_BASE = 224
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic [N_CH-1:0]   mask,
  input  logic [N_CH-1:0]   pend,
  input  logic [7:0]        wb_byte,
  input  logic [7:0]        mem_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              doorbell,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [IDX_W-1:0]  out_idx,
  output logic              out_last,
  output logic              arm,
  output logic              wb_done,
  output logic [CH_W-1:0]   cur_chan,
  output logic [IDX_W-1:0]  cur_idx
);

  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(MSG_BYTES - 1);
  localparam logic [CH_W-1:0]   LAST_CH  = CH_W'(N_CH - 1);
  localparam logic [ADDR_W-1:0] ST_LO    = ADDR_W'(STATE_BASE);
  localparam logic [ADDR_W-1:0] ST_HI    = ADDR_W'(STATE_BASE + N_CH);

  seq_state_e       st_q, st_d;
  logic [CH_W-1:0]  ch_q, ch_d, low_ch;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             scan_q, scan_d, step;
  logic             ov_q;
  logic [CH_W-1:0]  oc_q;
  logic [IDX_W-1:0] oi_q;
  logic [ADDR_W-1:0] state_addr, msg_addr;

  assign state_addr = ST_LO + ADDR_W'(ch_q);
  assign msg_addr   = ADDR_W'(MSG_BASE) + ADDR_W'(ch_q) * ADDR_W'(MSG_BYTES)
                    + ADDR_W'(idx_q);

  // Lowest parked reply wins
  always_comb begin
    low_ch = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (pend[i]) low_ch = CH_W'(i);
  end

  always_comb begin
    st_d      = st_q;
    ch_d      = ch_q;
    idx_d     = idx_q;
    scan_d    = scan_q | irq;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = state_addr;
    mem_wdata = '0;
    doorbell  = 1'b0;
    arm       = 1'b0;
    wb_done   = 1'b0;
    step      = 1'b0;
    case (st_q)
      E_IDLE: begin
        if (scan_q) begin
          scan_d = irq;
          ch_d   = '0;
          st_d   = E_ST_RD;
        end else if (|pend) begin
          ch_d  = low_ch;
          idx_d = '0;
          st_d  = E_WB;
        end
      end
      E_ST_RD: begin
        mem_en = 1'b1;
        st_d   = E_ST_CHK;
      end
      E_ST_CHK: begin
        if (mem_rdata == SLOT_NEW) begin
          idx_d = '0;
          st_d  = E_COPY;
        end else begin
          step = 1'b1;
        end
      end
      E_COPY: begin
        mem_en   = 1'b1;
        mem_addr = msg_addr;
        idx_d    = idx_q + 1'b1;
        if (idx_q == LAST_IDX) st_d = E_TAIL;
      end
      E_TAIL: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = SLOT_TAKEN;
        if (mask[ch_q]) begin
          arm  = 1'b1;
          step = 1'b1;
        end else begin
          st_d = E_AUTO;
        end
      end
      E_AUTO: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = SLOT_DONE;
        doorbell  = 1'b1;
        step      = 1'b1;
      end
      E_WB: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = msg_addr;
        mem_wdata = wb_byte;
        idx_d     = idx_q + 1'b1;
        if (idx_q == LAST_IDX) st_d = E_WB_FIN;
      end
      E_WB_FIN: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = SLOT_DONE;
        doorbell  = 1'b1;
        wb_done   = 1'b1;
        st_d      = E_IDLE;
      end
      default: st_d = E_IDLE;
    endcase
    if (step) begin
      if (ch_q == LAST_CH) begin
        st_d = E_IDLE;
      end else begin
        ch_d = ch_q + 1'b1;
        st_d = E_ST_RD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      ch_q   <= '0;
      idx_q  <= '0;
      scan_q <= 1'b0;
      ov_q   <= 1'b0;
      oc_q   <= '0;
      oi_q   <= '0;
    end else begin
      st_q   <= st_d;
      ch_q   <= ch_d;
      idx_q  <= idx_d;
      scan_q <= scan_d;
      ov_q   <= (st_q == E_COPY);
      oc_q   <= ch_q;
      oi_q   <= idx_q;
    end
  end

  assign out_valid = ov_q;
  assign out_chan  = oc_q;
  assign out_idx   = oi_q;
  assign out_last  = ov_q & (oi_q == LAST_IDX);
  assign cur_chan  = ch_q;
  assign cur_idx   = idx_q;

  // R7: no state byte is ever returned to idle by this side
  a_r7_never_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && mem_addr >= ST_LO && mem_addr < ST_HI)
      |-> (mem_wdata != SLOT_IDLE));

  // R2: streamed bytes of one message are gapless and in index order
  a_r2_stream_contig: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && out_idx == $past(out_idx) + 1'b1
                                  && out_chan == $past(out_chan)));

  // R3: the last byte coincides with the taken-state write for that channel
  a_r3_taken_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (mem_en && mem_we && mem_wdata == SLOT_TAKEN
                  && mem_addr == ST_LO + ADDR_W'(out_chan)));

  // R5: the doorbell is a single-cycle pulse
  a_r5_doorbell_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell);

endmodule

// File: rtl/mbox_rx_engine.sv
module mbox_rx_engine #(
  parameter int N_CH       = 7,
  parameter int MSG_BYTES  = 32,
  parameter int ADDR_W     = 8,
  parameter int MSG_BASE   = 0,
  parameter int STATE_BASE = 224,
  localparam int CH_W      = $clog2(N_CH),
  localparam int IDX_W     = $clog2(MSG_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   irq_msg,
  input  logic                   cons_set,
  input  logic                   cons_clr,
  input  logic [CH_W-1:0]        cons_chan,
  output logic                   cons_reject,
  input  logic                   rep_valid,
  input  logic [CH_W-1:0]        rep_chan,
  input  logic [MSG_BYTES*8-1:0] rep_data,
  output logic                   rep_err,
  output logic                   out_valid,
  output logic [CH_W-1:0]        out_chan,
  output logic [IDX_W-1:0]       out_idx,
  output logic [7:0]             out_byte,
  output logic                   out_last,
  output logic                   mem_en,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [7:0]             mem_wdata,
  input  logic [7:0]             mem_rdata,
  output logic                   doorbell
);

  logic [N_CH-1:0]  mask, pend;
  logic [7:0]       wb_byte;
  logic             arm, wb_done;
  logic [CH_W-1:0]  cur_chan;
  logic [IDX_W-1:0] cur_idx;

  mbox_rx_consumers #(.N_CH(N_CH), .CH_W(CH_W)) u_cons (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (cons_set),
    .clr_req (cons_clr),
    .chan    (cons_chan),
    .mask    (mask),
    .reject  (cons_reject)
  );

  mbox_rx_replies #(.N_CH(N_CH), .CH_W(CH_W), .MSG_BYTES(MSG_BYTES),
                    .IDX_W(IDX_W)) u_rep (
    .clk       (clk),
    .rst_n     (rst_n),
    .rep_valid (rep_valid),
    .rep_chan  (rep_chan),
    .rep_data  (rep_data),
    .arm       (arm),
    .wb_done   (wb_done),
    .cur_chan  (cur_chan),
    .rd_idx    (cur_idx),
    .rd_byte   (wb_byte),
    .pend      (pend),
    .rep_err   (rep_err)
  );

  mbox_rx_seq #(.N_CH(N_CH), .CH_W(CH_W), .MSG_BYTES(MSG_BYTES), .IDX_W(IDX_W),
                .ADDR_W(ADDR_W), .MSG_BASE(MSG_BASE),
                .STATE_BASE(STATE_BASE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq_msg),
    .mask      (mask),
    .pend      (pend),
    .wb_byte   (wb_byte),
    .mem_rdata (mem_rdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .doorbell  (doorbell),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_idx   (out_idx),
    .out_last  (out_last),
    .arm       (arm),
    .wb_done   (wb_done),
    .cur_chan  (cur_chan),
    .cur_idx   (cur_idx)
  );

  assign out_byte = mem_rdata;

endmodule

// File: tb/mbox_rx_engine_test.sv
module mbox_rx_engine_test;

  localparam int STB = 224;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         irq_msg = 1'b0;
  logic         cons_set = 1'b0, cons_clr = 1'b0;
  logic [2:0]   cons_chan = '0;
  logic         cons_reject;
  logic         rep_valid = 1'b0;
  logic [2:0]   rep_chan = '0;
  logic [255:0] rep_data = '0;
  logic         rep_err;
  logic         out_valid, out_last;
  logic [2:0]   out_chan;
  logic [4:0]   out_idx;
  logic [7:0]   out_byte;
  logic         mem_en, mem_we;
  logic [7:0]   mem_addr, mem_wdata, mem_rdata;
  logic         doorbell;

  logic         poke_en = 1'b0;
  logic [7:0]   poke_addr = '0, poke_data = '0;
  logic [7:0]   ram [256];
  logic [7:0]   rd_q = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Monitor logs
  logic [7:0] cap [8][32];
  int cap_n, ord_n, wl_n, msg_wr, db_n, rej_n, err_n, zero_wr;
  int ord [16];
  int wl_a [64];
  int wl_d [64];

  always #2 clk = ~clk;

  mbox_rx_engine uut (
    .clk(clk), .rst_n(rst_n), .irq_msg(irq_msg),
    .cons_set(cons_set), .cons_clr(cons_clr), .cons_chan(cons_chan),
    .cons_reject(cons_reject),
    .rep_valid(rep_valid), .rep_chan(rep_chan), .rep_data(rep_data),
    .rep_err(rep_err),
    .out_valid(out_valid), .out_chan(out_chan), .out_idx(out_idx),
    .out_byte(out_byte), .out_last(out_last),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .doorbell(doorbell)
  );

  // Shared RAM model, one-cycle read latency
  always @(posedge clk) begin
    if (poke_en) ram[poke_addr] <= poke_data;
    else if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) rd_q <= ram[mem_addr];
  end
  assign mem_rdata = rd_q;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        cap[out_chan][out_idx] = out_byte;
        cap_n++;
        if (out_idx == 5'd0 && ord_n < 16) begin ord[ord_n] = out_chan; ord_n++; end
      end
      if (mem_en && mem_we) begin
        if (mem_addr >= 8'(STB)) begin
          if (wl_n < 64) begin wl_a[wl_n] = mem_addr; wl_d[wl_n] = mem_wdata; end
          wl_n++;
          if (mem_wdata == 8'h00) zero_wr++;
        end else msg_wr++;
      end
      if (doorbell) db_n++;
      if (cons_reject) rej_n++;
      if (rep_err) err_n++;
    end
  end

  function automatic logic [7:0] pat(int c, int i);
    return 8'(c * 37 + i * 3 + 5);
  endfunction

  function automatic logic [7:0] rpl(int c, int i);
    return 8'(8'hC0 ^ (c * 11 + i));
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    cap_n = 0; ord_n = 0; wl_n = 0; msg_wr = 0; db_n = 0; rej_n = 0; err_n = 0;
  endtask

  task automatic poke(int a, int d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = 8'(a); poke_data = 8'(d);
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic load_msg(int c);
    for (int i = 0; i < 32; i++) poke(c * 32 + i, pat(c, i));
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_msg = 1'b1;
    @(negedge clk); irq_msg = 1'b0;
  endtask

  task automatic reg_op(bit s, bit c, int ch);
    @(negedge clk); cons_set = s; cons_clr = c; cons_chan = 3'(ch);
    @(negedge clk); cons_set = 1'b0; cons_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_reply(int ch);
    @(negedge clk);
    rep_valid = 1'b1; rep_chan = 3'(ch);
    for (int i = 0; i < 32; i++) rep_data[8*i +: 8] = rpl(ch, i);
    @(negedge clk);
    rep_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  function automatic int byte_errs(int c, bit reply);
    int e = 0;
    for (int i = 0; i < 32; i++)
      if (cap[c][i] !== (reply ? rpl(c, i) : pat(c, i))) e++;
    return e;
  endfunction

  function automatic int slot_errs(int c, bit reply);
    int e = 0;
    for (int i = 0; i < 32; i++)
      if (ram[c * 32 + i] !== (reply ? rpl(c, i) : pat(c, i))) e++;
    return e;
  endfunction

  task automatic t_reset();
    chk("R1", int'(doorbell), 0, "doorbell after reset");
    chk("R1", int'(out_valid), 0, "out_valid after reset");
    chk("R1", int'(out_last), 0, "out_last after reset");
    chk("R1", int'(mem_en), 0, "mem_en after reset");
    chk("R1", int'(rep_err), 0, "rep_err after reset");
    chk("R1", int'(cons_reject), 0, "cons_reject after reset");
  endtask

  task automatic t_unregistered();
    load_msg(2);
    poke(STB + 2, 1);
    clear_logs();
    pulse_irq();
    settle();
    chk("R2", cap_n, 32, "bytes streamed ch2");
    chk("R2", ord[0], 2, "streamed channel");
    chk("R2", byte_errs(2, 0), 0, "stream byte mismatches ch2");
    chk("R3", wl_n, 2, "state writes");
    chk("R3", wl_a[0], STB + 2, "first state write address");
    chk("R3", wl_d[0], 2, "first state write is taken");
    chk("R6", wl_d[1], 3, "auto finish code");
    chk("R6", db_n, 1, "doorbells on auto finish");
    chk("R6", msg_wr, 0, "slot writes on auto finish");
    chk("R6", slot_errs(2, 0), 0, "slot bytes ch2 unchanged");
    chk("R7", int'(ram[STB + 3]), 0, "untouched state ch3");
  endtask

  task automatic t_registration();
    clear_logs();
    reg_op(1, 0, 1);
    chk("R8", rej_n, 0, "first registration ch1");
    reg_op(1, 0, 4);
    reg_op(1, 0, 1);
    chk("R8", rej_n, 1, "duplicate registration ch1");
    reg_op(1, 0, 7);
    chk("R8", rej_n, 2, "registration on channel 7");
    reg_op(0, 1, 3);
    chk("R8", rej_n, 2, "clear is never refused");
  endtask

  task automatic t_mixed();
    poke(STB + 0, 2);
    load_msg(1); load_msg(4); load_msg(5);
    poke(STB + 1, 1); poke(STB + 4, 1); poke(STB + 5, 1);
    clear_logs();
    pulse_irq();
    settle();
    chk("R2", ord_n, 3, "messages streamed");
    chk("R2", ord[0], 1, "order slot 0");
    chk("R2", ord[1], 4, "order slot 1");
    chk("R2", ord[2], 5, "order slot 2");
    chk("R2", byte_errs(1, 0) + byte_errs(4, 0) + byte_errs(5, 0), 0,
        "stream byte mismatches");
    chk("R3", wl_n, 4, "state writes");
    chk("R4", int'(ram[STB + 1]), 2, "registered ch1 held taken");
    chk("R4", int'(ram[STB + 4]), 2, "registered ch4 held taken");
    chk("R4", db_n, 1, "doorbells with two waiting");
    chk("R6", int'(ram[STB + 5]), 3, "unregistered ch5 finished");
    chk("R7", int'(ram[STB + 0]), 2, "stale taken ch0 untouched");
  endtask

  task automatic t_replies();
    poke(STB + 6, 1);
    load_msg(6);
    load_msg(0);
    clear_logs();
    pulse_irq();
    send_reply(4);
    send_reply(1);
    send_reply(4);
    send_reply(0);
    send_reply(7);
    settle();
    chk("R9", err_n, 3, "refused replies");
    chk("R10", wl_n, 4, "state writes");
    chk("R10", wl_a[2], STB + 1, "first write-back channel");
    chk("R10", wl_a[3], STB + 4, "second write-back channel");
    chk("R5", wl_d[2] + wl_d[3], 6, "finish codes after replies");
    chk("R5", db_n, 3, "doorbells");
    chk("R5", msg_wr, 64, "reply bytes written");
    chk("R5", slot_errs(1, 1) + slot_errs(4, 1), 0, "reply slot mismatches");
    chk("R9", slot_errs(0, 0), 0, "slot ch0 unchanged by refused reply");
  endtask

  task automatic t_after();
    clear_logs();
    send_reply(1);
    repeat (5) @(negedge clk);
    chk("R9", err_n, 1, "reply after finish refused");
    chk("R9", msg_wr, 0, "no write from refused reply");
    reg_op(0, 1, 4);
    poke(STB + 4, 1);
    clear_logs();
    pulse_irq();
    settle();
    chk("R8", wl_n, 2, "state writes after clear");
    chk("R8", wl_d[1], 3, "cleared ch4 auto finished");
    chk("R8", db_n, 1, "doorbell after clear");
    chk("R2", byte_errs(4, 1), 0, "stream of ch4 slot");
    chk("R7", zero_wr, 0, "idle writes over run");
  endtask

  initial begin
    zero_wr = 0;
    clear_logs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    for (int a = 0; a < 256; a++) poke(a, 0);
    t_reset();
    t_unregistered();
    t_registration();
    t_mixed();
    t_replies();
    t_after();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL all watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule